// File: doc/BRIEF.md
# Microcoded Address Generation Unit

This unit produces one word address per clock for a set of flat memories made of 16-bit words. The memories are two scratchpads, an input memory and an output memory. A microcode field drives it every cycle. The unit holds a base register and a stride register, and the two share a single adder. Either register can be loaded from the operand supplied by the paired execution unit or from the microcode immediate. The address itself is combinational from the register values of the current cycle. Every register change lands at the next clock edge.

Four addressing modes are available: the immediate itself, the base register, base plus immediate, and a strided walk. The strided walk emits the base and then advances it by the stride. The memory select and the read/write intent from the microcode pass straight through to the outputs beside the address. The address wraps to the depth of the selected memory. No scaled mode exists, because every memory is indexed directly in words.

Top module: `addr_gen_unit`

## Requirements
- R1: After reset, both the base and the stride register hold zero, so mode 01 (base) drives address 0.
- R2: Mode 00 drives the microcode immediate, wrapped to the selected memory depth.
- R3: Mode 01 drives the base register, wrapped to the selected memory depth.
- R4: Mode 10 drives base plus immediate, wrapped to the selected memory depth, and leaves the base unchanged.
- R5: Mode 11 drives the current base. When the access strobe is high, the base becomes base plus stride (modulo 2048) at the next edge. When the access strobe is low, the base keeps its value.
- R6: A base or stride load takes the low 11 bits of the execution-unit operand when the source select is 1, and the immediate when it is 0. The loaded value becomes visible from the next cycle on.
- R7: When a base load and a strided post-update fall in the same cycle, the load wins. The address in that cycle is still the old base.
- R8: The memory select codes are 0 = scratch 0, 1 = scratch 1, 2 = input and 3 = output. Input addresses wrap modulo 2048. All other memories wrap modulo 1024, so address bit 10 is zero for them.
- R9: The memory select output mirrors the select input. Read strobe = access AND NOT write, and write strobe = access AND write. Neither strobe is high while access is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ucAccess | input | 1 | Microcode: perform a memory access this cycle |
| ucWrite | input | 1 | Microcode: 1 = write, 0 = read |
| ucMemSel | input | 2 | Microcode: target memory code |
| ucMode | input | 2 | Microcode: addressing mode |
| ucImm | input | 11 | Microcode immediate |
| ucLdBase | input | 1 | Microcode: load the base register |
| ucLdStride | input | 1 | Microcode: load the stride register |
| ucLdSrcPu | input | 1 | Load source: 1 = execution-unit operand, 0 = immediate |
| puData | input | 16 | Operand from the paired execution unit |
| addrOut | output | 11 | Word address |
| memSelOut | output | 2 | Target memory code passed through |
| rdEn | output | 1 | Read strobe |
| wrEn | output | 1 | Write strobe |

## Verification
The hardest situation to reach is a base load that collides with a strided post-update while the base sits near the top of a 1024-word memory. In that case the priority, the old-base address in the collision cycle and the narrow wrap all matter at once. Directed steps build this exact sequence: a base of 1000, a stride loaded from an operand with high junk bits, displaced accesses that cross 1024 for both a narrow and a wide memory, and then a strided access with a concurrent load. A long run of seeded random microcode follows. It is checked every cycle against a bench model of the two registers.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [1:0] {
    MODE_IMM    = 2'd0,
    MODE_BASE   = 2'd1,
    MODE_DISP   = 2'd2,
    MODE_STRIDE = 2'd3
  } aguMode_e;

  typedef enum logic [1:0] {
    MEM_SCR0 = 2'd0,
    MEM_SCR1 = 2'd1,
    MEM_IN   = 2'd2,
    MEM_OUT  = 2'd3
  } aguMem_e;

  typedef struct packed {
    logic outImm;
    logic outSum;
    logic addStride;
    logic bumpBase;
    logic ldBase;
    logic ldStride;
    logic ldFromPu;
    logic wideMem;
  } aguStrobe_t;

endpackage

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import agu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] ucMode,
  input  logic       ucAccess,
  input  logic       ucWrite,
  input  logic [1:0] ucMemSel,
  input  logic       ucLdBase,
  input  logic       ucLdStride,
  input  logic       ucLdSrcPu,
  output aguStrobe_t strb,
  output logic [1:0] memSelOut,
  output logic       rdEn,
  output logic       wrEn
);

  aguMode_e modeE;
  assign modeE = aguMode_e'(ucMode);

  always_comb begin
    strb           = '0;
    strb.ldBase    = ucLdBase;
    strb.ldStride  = ucLdStride;
    strb.ldFromPu  = ucLdSrcPu;
    strb.wideMem   = (aguMem_e'(ucMemSel) == MEM_IN);
    unique case (modeE)
      MODE_IMM:    strb.outImm = 1'b1;
      MODE_BASE:   ;
      MODE_DISP:   strb.outSum = 1'b1;
      MODE_STRIDE: begin
        strb.addStride = 1'b1;
        strb.bumpBase  = ucAccess;
      end
      default: ;
    endcase
  end

  assign memSelOut = ucMemSel;
  assign rdEn      = ucAccess & ~ucWrite;
  assign wrEn      = ucAccess & ucWrite;

  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEn && wrEn)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !ucAccess |-> (!rdEn && !wrEn && !strb.bumpBase)); // R9

endmodule

// File: rtl/agu_datapath.sv
module agu_datapath
  import agu_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 11,
  parameter int NARROW_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  aguStrobe_t        strb,
  input  logic [ADDR_W-1:0] imm,
  input  logic [DATA_W-1:0] puData,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] baseVal,
  output logic [ADDR_W-1:0] strideVal
);

  localparam logic [ADDR_W-1:0] WIDE_MASK   = '1;
  localparam logic [ADDR_W-1:0] NARROW_MASK =
    {{(ADDR_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [ADDR_W-1:0] baseQ, strideQ;
  logic [ADDR_W-1:0] puAddr, loadVal, adderB, sum, rawAddr, depthMask;

  generate
    if (DATA_W >= ADDR_W) begin : g_slice
      assign puAddr = puData[ADDR_W-1:0];
    end else begin : g_extend
      assign puAddr = {{(ADDR_W-DATA_W){1'b0}}, puData};
    end
  endgenerate

  assign loadVal   = strb.ldFromPu ? puAddr : imm;
  assign adderB    = strb.addStride ? strideQ : imm;
  assign sum       = baseQ + adderB;
  assign rawAddr   = strb.outImm ? imm : (strb.outSum ? sum : baseQ);
  assign depthMask = strb.wideMem ? WIDE_MASK : NARROW_MASK;
  assign addr      = rawAddr & depthMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ   <= '0;
      strideQ <= '0;
    end else begin
      if (strb.ldBase)        baseQ <= loadVal;
      else if (strb.bumpBase) baseQ <= sum;
      if (strb.ldStride)      strideQ <= loadVal;
    end
  end

  assign baseVal   = baseQ;
  assign strideVal = strideQ;

  AST_STRIDE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ldStride |=> $stable(strideQ)); // R6

endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit
  import agu_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 11,
  parameter int NARROW_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ucAccess,
  input  logic              ucWrite,
  input  logic [1:0]        ucMemSel,
  input  logic [1:0]        ucMode,
  input  logic [ADDR_W-1:0] ucImm,
  input  logic              ucLdBase,
  input  logic              ucLdStride,
  input  logic              ucLdSrcPu,
  input  logic [DATA_W-1:0] puData,
  output logic [ADDR_W-1:0] addrOut,
  output logic [1:0]        memSelOut,
  output logic              rdEn,
  output logic              wrEn
);

  aguStrobe_t        strb;
  logic [ADDR_W-1:0] baseVal, strideVal;

  agu_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ucMode    (ucMode),
    .ucAccess  (ucAccess),
    .ucWrite   (ucWrite),
    .ucMemSel  (ucMemSel),
    .ucLdBase  (ucLdBase),
    .ucLdStride(ucLdStride),
    .ucLdSrcPu (ucLdSrcPu),
    .strb      (strb),
    .memSelOut (memSelOut),
    .rdEn      (rdEn),
    .wrEn      (wrEn)
  );

  agu_datapath #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .NARROW_W(NARROW_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .imm      (ucImm),
    .puData   (puData),
    .addr     (addrOut),
    .baseVal  (baseVal),
    .strideVal(strideVal)
  );

  AST_STRIDE_BUMP: assert property (@(posedge clk) disable iff (!rstN)
    (ucMode == MODE_STRIDE && ucAccess && !ucLdBase)
      |=> baseVal == $past(baseVal + strideVal)); // R5

  AST_BASE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!ucAccess && !ucLdBase) |=> $stable(baseVal)); // R5

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (ucLdBase && !ucLdSrcPu) |=> baseVal == $past(ucImm)); // R7

  AST_NARROW_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (ucMemSel != MEM_IN) |-> addrOut[ADDR_W-1:NARROW_W] == '0); // R8

  AST_IMM_WIDE: assert property (@(posedge clk) disable iff (!rstN)
    (ucMode == MODE_IMM && ucMemSel == MEM_IN) |-> addrOut == ucImm); // R2

  AST_DISP_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (ucMode == MODE_DISP && !ucLdBase) |=> $stable(baseVal)); // R4

endmodule

// File: tb/sim_addr_gen_unit.sv
module sim_addr_gen_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ucAccess = 1'b0, ucWrite = 1'b0;
  logic [1:0]  ucMemSel = 2'd0, ucMode = 2'd1;
  logic [10:0] ucImm = '0;
  logic        ucLdBase = 1'b0, ucLdStride = 1'b0, ucLdSrcPu = 1'b0;
  logic [15:0] puData = '0;
  logic [10:0] addrOut;
  logic [1:0]  memSelOut;
  logic        rdEn, wrEn;

  int total = 0;
  int fails = 0;
  logic [10:0] mBase = '0, mStride = '0;

  always #2 clk = ~clk;

  addr_gen_unit u0 (
    .clk(clk), .rstN(rstN), .ucAccess(ucAccess), .ucWrite(ucWrite),
    .ucMemSel(ucMemSel), .ucMode(ucMode), .ucImm(ucImm),
    .ucLdBase(ucLdBase), .ucLdStride(ucLdStride), .ucLdSrcPu(ucLdSrcPu),
    .puData(puData), .addrOut(addrOut), .memSelOut(memSelOut),
    .rdEn(rdEn), .wrEn(wrEn)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [10:0] expAddr(input logic [1:0] md, input logic [10:0] im,
                                          input logic [1:0] ms);
    logic [10:0] raw;
    case (md)
      2'd0:    raw = im;
      2'd1:    raw = mBase;
      2'd2:    raw = mBase + im;
      default: raw = mBase;
    endcase
    return (ms == 2'd2) ? raw : (raw & 11'h3FF);
  endfunction

  function automatic string modeTag(input logic [1:0] md);
    case (md)
      2'd0:    return "R2 immediate";
      2'd1:    return "R3 base";
      2'd2:    return "R4 displaced";
      default: return "R5 strided";
    endcase
  endfunction

  task automatic step(input logic [1:0] md, input logic acc, input logic wr,
                      input logic [1:0] ms, input logic [10:0] im,
                      input logic lb, input logic ls, input logic src,
                      input logic [15:0] pd, input string tag);
    logic [10:0] ldv;
    @(negedge clk);
    ucMode = md; ucAccess = acc; ucWrite = wr; ucMemSel = ms; ucImm = im;
    ucLdBase = lb; ucLdStride = ls; ucLdSrcPu = src; puData = pd;
    #1;
    check((tag.len() != 0) ? tag : modeTag(md), int'(addrOut), int'(expAddr(md, im, ms)));
    check("R9 memSel", int'(memSelOut), int'(ms));
    check("R9 rdEn", int'(rdEn), int'(acc & ~wr));
    check("R9 wrEn", int'(wrEn), int'(acc & wr));
    @(posedge clk);
    ldv = src ? pd[10:0] : im;
    if (lb) mBase = ldv;
    else if (md == 2'd3 && acc) mBase = mBase + mStride;
    if (ls) mStride = ldv;
  endtask

  initial begin
    #(4 * 200000);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    ucMode = 2'd1;
    #9;
    check("R1 reset address", int'(addrOut), 0);
    @(negedge clk); rstN = 1'b1;
    step(2'd1, 1'b0, 1'b0, 2'd0, 11'd0, 1'b0, 1'b0, 1'b0, 16'h0, "R1 base after reset");
    step(2'd0, 1'b0, 1'b0, 2'd0, 11'd1000, 1'b1, 1'b0, 1'b0, 16'h0, "R6 load base imm");
    step(2'd1, 1'b1, 1'b0, 2'd0, 11'd0, 1'b0, 1'b1, 1'b1, 16'hF805, "R6 base visible");
    step(2'd2, 1'b1, 1'b0, 2'd0, 11'd100, 1'b0, 1'b0, 1'b0, 16'h0, "R8 narrow wrap");
    step(2'd2, 1'b1, 1'b1, 2'd2, 11'd100, 1'b0, 1'b0, 1'b0, 16'h0, "R8 input wide");
    step(2'd2, 1'b1, 1'b0, 2'd3, 11'd100, 1'b0, 1'b0, 1'b0, 16'h0, "R8 output wrap");
    step(2'd3, 1'b1, 1'b0, 2'd1, 11'd0, 1'b0, 1'b0, 1'b0, 16'h0, "R5 strided first");
    step(2'd3, 1'b0, 1'b0, 2'd1, 11'd0, 1'b0, 1'b0, 1'b0, 16'h0, "R5 strided bumped");
    step(2'd1, 1'b0, 1'b0, 2'd2, 11'd0, 1'b0, 1'b0, 1'b0, 16'h0, "R5 no bump idle");
    step(2'd3, 1'b1, 1'b1, 2'd0, 11'd7, 1'b1, 1'b0, 1'b0, 16'h0, "R7 collision old base");
    step(2'd1, 1'b0, 1'b0, 2'd2, 11'd0, 1'b0, 1'b0, 1'b0, 16'h0, "R7 load wins");
    step(2'd0, 1'b1, 1'b0, 2'd0, 11'd2047, 1'b0, 1'b0, 1'b0, 16'h0, "R2 R8 imm wrap");
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[1:0], (r[3:2] != 2'b00), r[4], r[6:5], 11'($urandom),
           (r[9:7] == 3'd0), (r[12:10] == 3'd0), r[13], 16'($urandom), "");
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule